// File: doc/BRIEF.md
# Repeated-Input Detector

This block watches two single-bit inputs, `inA` and `inB`, on every rising clock edge and drives a single flag, `outZ`. The flag goes high once the two most recent `inA` samples are equal. It then stays high for as long as `inB` is sampled at 1 on every following edge, even if `inA` stops repeating. When `inA` changes while `inB` is 0, the flag falls.

The design is a Moore machine held in three D flip-flops. `outZ` is decoded from the stored state alone, so it never follows the inputs combinationally. The stored state code is also brought out as `stateDbg` for observation. Its bit 2 means "at least one sample seen", bit 1 means "flag condition active", and bit 0 holds the most recent `inA` value.

A synchronous active-high reset returns the machine to its empty state. The block expects `inA` and `inB` to be already synchronous to `clk`.

Top module: `repeat_detect`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, leaves `stateDbg` at 3'b000 and `outZ` at 0 after that edge, whatever the inputs are.
- R2: From the empty code 3'b000, the first non-reset edge moves the machine to 3'b100 if `inA` was 0, or to 3'b101 if `inA` was 1. `outZ` stays 0.
- R3: At an edge where a previous sample exists and `inA` equals the previous `inA` sample, the machine goes to 3'b110 (repeated 0) or 3'b111 (repeated 1), and `outZ` is 1 after that edge. This holds regardless of `inB`.
- R4: At an edge where `outZ` is 1, `inB` is 1 and `inA` differs from the previous sample, `outZ` stays 1. The code becomes 3'b110 or 3'b111, with bit 0 taking the new `inA` value.
- R5: At an edge where `inA` differs from the previous sample and the flag is not held by `inB`, `outZ` is 0 after that edge. The code becomes 3'b100 or 3'b101, with bit 0 taking the new `inA` value.
- R6: `stateDbg` only ever takes the codes 000, 100, 101, 110 and 111. `outZ` is 1 exactly when `stateDbg[2:1]` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inA | input | 1 | Sampled input whose repetition is detected |
| inB | input | 1 | Hold input that keeps the flag set while it stays 1 |
| outZ | output | 1 | Detector flag, decoded from state only |
| stateDbg | output | 3 | Present state code |

## Verification
The bench drives several kinds of input pattern:
- Runs of a constant `inA` separate the repeat rule (R3) from the first-sample rule (R2).
- Alternating `inA` with `inB` held at 1 shows the hold path keeping the flag (R4).
- The same alternation with `inB` at 0 shows the flag dropping (R5).
- Resets issued mid-stream, including while the flag is high, show that no memory of earlier samples survives.

A long seeded random stream of `inA`, `inB` and occasional resets is then compared edge by edge against a reference. The reference keeps only the last `inA` sample, a count of samples seen and a sticky flag. This exercises every transition, including a repeat with `inB` low and a hold that switches between the two repeated codes.

// File: rtl/repeat_detect_pkg.sv
package repeat_detect_pkg;

  localparam int STATE_W = 3;

  // Bit meaning: [2] a sample has been seen, [1] flag active, [0] last A value
  localparam int SEEN_BIT  = 2;
  localparam int MATCH_BIT = 1;
  localparam int LASTA_BIT = 0;

  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY  = 3'b000,
    ST_SEEN0  = 3'b100,
    ST_SEEN1  = 3'b101,
    ST_MATCH0 = 3'b110,
    ST_MATCH1 = 3'b111
  } stateE;

  typedef struct packed {
    logic               forceEmpty;
    logic [STATE_W-1:0] nextCode;
  } ctrlStrobeT;

endpackage

// File: rtl/repeat_detect_ctrl.sv
module repeat_detect_ctrl
  import repeat_detect_pkg::*;
(
  input  logic               rst,
  input  logic               inA,
  input  logic               inB,
  input  logic [STATE_W-1:0] stateCode,
  output ctrlStrobeT         strobe
);

  logic lastA;
  assign lastA = stateCode[LASTA_BIT];

  always_comb begin
    strobe.forceEmpty = rst;
    strobe.nextCode   = ST_EMPTY;
    case (stateCode)
      ST_EMPTY: begin
        strobe.nextCode = inA ? ST_SEEN1 : ST_SEEN0;
      end
      ST_SEEN0, ST_SEEN1: begin
        if (inA == lastA) strobe.nextCode = inA ? ST_MATCH1 : ST_MATCH0;
        else              strobe.nextCode = inA ? ST_SEEN1  : ST_SEEN0;
      end
      ST_MATCH0, ST_MATCH1: begin
        if ((inA == lastA) || inB) strobe.nextCode = inA ? ST_MATCH1 : ST_MATCH0;
        else                       strobe.nextCode = inA ? ST_SEEN1  : ST_SEEN0;
      end
      default: begin
        strobe.nextCode = ST_EMPTY;
      end
    endcase
  end

endmodule

// File: rtl/repeat_detect_dp.sv
module repeat_detect_dp
  import repeat_detect_pkg::*;
(
  input  logic               clk,
  input  ctrlStrobeT         strobe,
  output logic [STATE_W-1:0] stateQ,
  output logic               outZ
);

  always_ff @(posedge clk) begin
    if (strobe.forceEmpty) stateQ <= ST_EMPTY;
    else                   stateQ <= strobe.nextCode;
  end

  assign outZ = stateQ[SEEN_BIT] & stateQ[MATCH_BIT];

endmodule

// File: rtl/repeat_detect.sv
module repeat_detect
  import repeat_detect_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inA,
  input  logic               inB,
  output logic               outZ,
  output logic [STATE_W-1:0] stateDbg
);

  ctrlStrobeT         strobe;
  logic [STATE_W-1:0] stateQ;

  repeat_detect_ctrl u_ctrl (
    .rst       (rst),
    .inA       (inA),
    .inB       (inB),
    .stateCode (stateQ),
    .strobe    (strobe)
  );

  repeat_detect_dp u_dp (
    .clk    (clk),
    .strobe (strobe),
    .stateQ (stateQ),
    .outZ   (outZ)
  );

  assign stateDbg = stateQ;

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stateDbg == 3'b000 && !outZ));

  // R2
  first_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (stateDbg == 3'b000) |=> (stateDbg[2:1] == 2'b10 && stateDbg[0] == $past(inA)));

  // R3
  repeat_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (stateDbg[2] && inA == stateDbg[0]) |=> (outZ && stateDbg[0] == $past(inA)));

  // R4
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (outZ && inB) |=> (outZ && stateDbg[0] == $past(inA)));

  // R5
  change_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (outZ && inA != stateDbg[0] && !inB) |=> (!outZ && stateDbg[2] && stateDbg[0] == $past(inA)));

  // R6
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    !(stateDbg inside {3'b001, 3'b010, 3'b011}));

endmodule

// File: tb/repeat_detect_tb.sv
module repeat_detect_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inA = 1'b0;
  logic       inB = 1'b0;
  logic       outZ;
  logic [2:0] stateDbg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  bit   haveA   = 1'b0;
  logic prevA   = 1'b0;
  logic stickyM = 1'b0;

  always #4 clk = ~clk;

  repeat_detect u_dut (
    .clk      (clk),
    .rst      (rst),
    .inA      (inA),
    .inB      (inB),
    .outZ     (outZ),
    .stateDbg (stateDbg)
  );

  function automatic logic [2:0] expCode();
    return haveA ? {1'b1, stickyM, prevA} : 3'b000;
  endfunction

  task automatic checkOut(input string tag);
    logic [2:0] ec;
    ec = expCode();
    nChecks++;
    if (outZ !== stickyM || stateDbg !== ec) begin
      nFails++;
      $display("FAIL %s: outZ=%b code=%b expected outZ=%b code=%b",
               tag, outZ, stateDbg, stickyM, ec);
    end
  endtask

  task automatic doStep(input logic a, input logic b, input logic r);
    string tag;
    bit    eq;
    @(negedge clk);
    inA = a; inB = b; rst = r;
    @(posedge clk);
    if (r) begin
      tag = "R1"; haveA = 1'b0; stickyM = 1'b0;
    end else begin
      eq = haveA && (a == prevA);
      if (!haveA)            tag = "R2";
      else if (eq)           tag = "R3";
      else if (stickyM && b) tag = "R4";
      else                   tag = "R5";
      stickyM = eq || (stickyM && b);
      prevA   = a;
      haveA   = 1'b1;
    end
    #2;
    checkOut(tag);
  endtask

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd24681357);
    // R1 reset state
    doStep(1'b1, 1'b1, 1'b1);
    doStep(1'b0, 1'b1, 1'b1);
    // R2 first samples, R3 repeat of 0 with B low
    doStep(1'b0, 1'b0, 1'b0);
    doStep(1'b0, 1'b0, 1'b0);
    doStep(1'b0, 1'b0, 1'b0);
    // R4 alternation with B high keeps flag
    doStep(1'b1, 1'b1, 1'b0);
    doStep(1'b0, 1'b1, 1'b0);
    doStep(1'b1, 1'b1, 1'b0);
    // R5 change with B low drops flag
    doStep(1'b0, 1'b0, 1'b0);
    doStep(1'b1, 1'b1, 1'b0);
    doStep(1'b1, 1'b0, 1'b0);
    // R1 reset while flag high, then R2 with A=1
    doStep(1'b1, 1'b1, 1'b1);
    doStep(1'b1, 1'b1, 1'b0);
    doStep(1'b0, 1'b1, 1'b0);
    doStep(1'b0, 1'b1, 1'b0);
    // R5 drop from repeated-1 code
    doStep(1'b1, 1'b1, 1'b0);
    doStep(1'b1, 1'b0, 1'b0);
    doStep(1'b0, 1'b0, 1'b0);
    // random stream, R6 code legality covered by every compare
    for (int i = 0; i < 4000; i++) begin
      doStep(1'($urandom() & 1), 1'($urandom() & 1), ($urandom() % 97) == 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule